// File: doc/BRIEF.md
# Two-Wire Serial Port with Address-Matching Slave and Firmware Pin Control

This block is a two-wire serial peripheral that sits on a small processor's register bus. It has two modes, and one bit of its control register selects between them. In slave mode a hardware engine watches the bus for a START condition. It compares the incoming 7-bit address against two programmable address registers and acknowledges on a match. It then moves bytes between the wire and a single data register, and raises a byte-complete flag after every byte it handles. In firmware master mode the engine is held idle. Three control bits drive the clock and data pins directly, and a fourth bit captures the data pin whenever the clock pin changes level. This lets software run the master side bit by bit.

Both pins use open-drain emulation. Each has an output `*_oe` that pulls the line low when high; otherwise the line is released and pulled up outside the block. The byte-complete flag is also the interrupt output, which the chip ORs with a neighbouring serial block. Both pin inputs pass through a synchroniser. START is a falling data edge while the clock is high, and STOP is a rising data edge while the clock is high.

Slave sequencer states:
- `S_IDLE`: waiting for START.
- `S_ADDR`: shifting in the address and the read/write bit.
- `S_AACK`: driving the address acknowledge.
- `S_RX`: shifting in a data byte.
- `S_RACK`: driving the data acknowledge.
- `S_TX`: shifting out a data byte.
- `S_TACK`: sampling the master's acknowledge.

Transitions:
- START from any state goes to `S_ADDR`, and STOP from any state goes to `S_IDLE`.
- From `S_ADDR`, the clock fall after the eighth bit goes to `S_AACK` on a match and to `S_IDLE` otherwise.
- `S_AACK` goes to `S_TX` when the read/write bit is 1 and to `S_RX` when it is 0.
- `S_RX` goes to `S_RACK` after eight bits, and `S_RACK` returns to `S_RX`.
- `S_TX` goes to `S_TACK` after eight bits.
- From `S_TACK`, a low (ACK) sample goes back to `S_TX` and a high (NACK) sample goes to `S_IDLE`.
- Master mode or the slave-hold bit forces `S_IDLE`.

Top module: `tw_serial_unit`

## Requirements
- R1: After reset the control register reads 0x00, the second address register (bus address 3) reads 0x7F, the first (bus address 2) and the data register (bus address 1) read 0x00, both pins are released and `irq` is 0. The control register sits at bus address 0.
- R2: With the mode bit (control bit 3) at 1 and the output-enable bit (bit 6) at 1, the data line follows the data-out bit (bit 7). With bit 6 at 0 the data line is released.
- R3: With the mode bit at 1, the clock line follows control bit 5.
- R4: With the mode bit at 1 and bit 6 at 0, each level change of the clock line copies the data line into control bit 4. Bit 4 does not change without a clock change or while bit 6 is 1, and bus writes to bit 4 are ignored.
- R5: In slave mode the engine pulls the data line low in the ninth clock only when the received address (first byte, bits 7:1) equals either address register. On a mismatch it does not acknowledge and ignores the bus until the next START.
- R6: When the read/write bit (first byte, bit 0) is 0, each following byte is acknowledged and its value appears in the data register.
- R7: When the read/write bit is 1, the data register is sent MSB first. It is reloaded after each master ACK. Control bit 1 reads 1 while the engine transmits and 0 once a master NACK has ended the read.
- R8: Control bit 0 and `irq` are set after every byte the engine handles, including a matched address. Reading the data register clears them. Bus writes to bit 0 have no effect.
- R9: With the slave-hold bit (control bit 2) at 1, the engine ignores the bus and acknowledges nothing.
- R10: A STOP returns the engine to waiting for START, even mid-byte. A repeated START begins a new address phase.
- R11: In slave mode the block never pulls the clock line, and the firmware pin bits do not reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 address A, 3 address B |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading data clears the flag) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| irq | output | 1 | Byte-complete interrupt |

## Verification
The slave engine is exercised with the following address patterns:
- Addresses matching the first register, addresses matching the default of the second, and random non-matching values. This separates a working compare from one that checks only a single register or acknowledges everything.
- Write transfers of one to three random bytes and read transfers with ACK followed by NACK. These distinguish correct shift order, reload timing and direction reporting.
- A repeated START, a STOP placed mid-address, and a transfer under slave hold. These show whether bus conditions override the byte sequencer.

Firmware pin mode is driven with random combinations of the three output bits. The capture bit is toggled with and without clock edges, which exposes a capture that runs on the wrong condition.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int DW = 8;
    localparam int AW = 7;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_ADRA = 2'd2;
    localparam logic [1:0] RA_ADRB = 2'd3;

    // control bit positions (software decodes these)
    localparam int CB_DOUT = 7;
    localparam int CB_DOE  = 6;
    localparam int CB_CLK  = 5;
    localparam int CB_DIN  = 4;
    localparam int CB_MODE = 3;
    localparam int CB_HOLD = 2;
    localparam int CB_DIR  = 1;
    localparam int CB_FLAG = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_RX,
        S_RACK,
        S_TX,
        S_TACK
    } slv_state_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             last;

    // idle bus level is high, so reset to ones to avoid false edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
            last <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
            last <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise[b] =  q[b] & ~last[b];
        assign fall[b] = ~q[b] &  last[b];
    end

endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          scl,
    input  logic          sda,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic [AW-1:0] adr_a,
    input  logic [AW-1:0] adr_b,
    input  logic [DW-1:0] tx_byte,
    output slv_state_e    state_o,
    output logic          sda_drive,
    output logic          xmit,
    output logic          byte_evt,
    output logic          rx_valid,
    output logic [DW-1:0] rx_byte
);

    localparam int CW = $clog2(DW + 1);

    slv_state_e    st, nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] txsh;
    logic          nack;
    logic          start_c, stop_c, cnt_full, hit;

    assign start_c  = sda_fall & scl;
    assign stop_c   = sda_rise & scl;
    assign cnt_full = (cnt == CW'(DW));
    assign hit      = (shreg[DW-1:1] == adr_a) || (shreg[DW-1:1] == adr_b);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: nxt = S_IDLE;
            S_ADDR: if (scl_fall && cnt_full) nxt = hit ? S_AACK : S_IDLE;
            S_AACK: if (scl_fall) nxt = shreg[0] ? S_TX : S_RX;
            S_RX:   if (scl_fall && cnt_full) nxt = S_RACK;
            S_RACK: if (scl_fall) nxt = S_RX;
            S_TX:   if (scl_fall && cnt_full) nxt = S_TACK;
            S_TACK: if (scl_fall) nxt = nack ? S_IDLE : S_TX;
            default: nxt = S_IDLE;
        endcase
        if (stop_c)  nxt = S_IDLE;
        if (start_c) nxt = S_ADDR;
        if (hold)    nxt = S_IDLE;
    end

    // datapath: bit counter, shift registers, acknowledge sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            txsh  <= '0;
            nack  <= 1'b1;
        end else begin
            if (nxt != st || start_c)
                cnt <= '0;
            else if (scl_rise && (st == S_ADDR || st == S_RX || st == S_TX))
                cnt <= cnt + 1'b1;

            if (scl_rise && (st == S_ADDR || st == S_RX))
                shreg <= {shreg[DW-2:0], sda};

            if (scl_rise && st == S_TACK)
                nack <= sda;

            if (nxt == S_TX && st != S_TX)
                txsh <= tx_byte;
            else if (st == S_TX && scl_fall)
                txsh <= {txsh[DW-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        sda_drive = 1'b0;
        unique case (st)
            S_AACK, S_RACK: sda_drive = 1'b1;
            S_TX:           sda_drive = ~txsh[DW-1];
            default:        sda_drive = 1'b0;
        endcase
        xmit     = (st == S_TX) || (st == S_TACK);
        rx_valid = (st == S_RX) && (nxt == S_RACK);
        byte_evt = ((st == S_ADDR) && (nxt == S_AACK)) || rx_valid ||
                   ((st == S_TX) && (nxt == S_TACK));
        rx_byte  = shreg;
        state_o  = st;
    end

endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
#(
    parameter logic [AW-1:0] ADRA_INIT = 7'h00,
    parameter logic [AW-1:0] ADRB_INIT = 7'h7F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          scl_edge,
    input  logic          sda_now,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          byte_evt,
    input  logic          xmit,
    output logic          ctl_dout,
    output logic          ctl_doe,
    output logic          ctl_clk,
    output logic          ctl_mode,
    output logic          ctl_hold,
    output logic [DW-1:0] tx_byte,
    output logic [AW-1:0] adr_a,
    output logic [AW-1:0] adr_b,
    output logic          flag
);

    logic din;
    logic wr_ctrl, wr_data, wr_adra, wr_adrb, rd_data;

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_data = bus_wr && (bus_addr == RA_DATA);
    assign wr_adra = bus_wr && (bus_addr == RA_ADRA);
    assign wr_adrb = bus_wr && (bus_addr == RA_ADRB);
    assign rd_data = bus_rd && (bus_addr == RA_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_dout <= 1'b0;
            ctl_doe  <= 1'b0;
            ctl_clk  <= 1'b0;
            ctl_mode <= 1'b0;
            ctl_hold <= 1'b0;
            din      <= 1'b0;
            flag     <= 1'b0;
            tx_byte  <= '0;
            adr_a    <= ADRA_INIT;
            adr_b    <= ADRB_INIT;
        end else begin
            if (wr_ctrl) begin
                ctl_dout <= bus_wdata[CB_DOUT];
                ctl_doe  <= bus_wdata[CB_DOE];
                ctl_clk  <= bus_wdata[CB_CLK];
                ctl_mode <= bus_wdata[CB_MODE];
                ctl_hold <= bus_wdata[CB_HOLD];
            end
            if (ctl_mode && !ctl_doe && scl_edge)
                din <= sda_now;
            if (rx_valid)     tx_byte <= rx_byte;
            else if (wr_data) tx_byte <= bus_wdata;
            if (wr_adra) adr_a <= bus_wdata[AW-1:0];
            if (wr_adrb) adr_b <= bus_wdata[AW-1:0];
            if (byte_evt)     flag <= 1'b1;
            else if (rd_data) flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_CTRL: begin
                bus_rdata[CB_DOUT] = ctl_dout;
                bus_rdata[CB_DOE]  = ctl_doe;
                bus_rdata[CB_CLK]  = ctl_clk;
                bus_rdata[CB_DIN]  = din;
                bus_rdata[CB_MODE] = ctl_mode;
                bus_rdata[CB_HOLD] = ctl_hold;
                bus_rdata[CB_DIR]  = xmit;
                bus_rdata[CB_FLAG] = flag;
            end
            RA_DATA: bus_rdata = tx_byte;
            RA_ADRA: bus_rdata = {1'b0, adr_a};
            RA_ADRB: bus_rdata = {1'b0, adr_b};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tw_serial_unit.sv
module tw_serial_unit
    import tw_pkg::*;
#(
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] ADRA_INIT   = 7'h00,
    parameter logic [AW-1:0] ADRB_INIT   = 7'h7F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          irq
);

    localparam int PINS = 2;

    logic [PINS-1:0] pin_q, pin_rise, pin_fall;
    logic            ctl_dout, ctl_doe, ctl_clk, ctl_mode, ctl_hold;
    logic [DW-1:0]   tx_byte, rx_byte;
    logic [AW-1:0]   adr_a, adr_b;
    logic            sda_drive, xmit, byte_evt, rx_valid;
    slv_state_e      eng_state;

    // bit 1 = clock, bit 0 = data
    tw_sync #(.STAGES(SYNC_STAGES), .W(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tw_slave_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (ctl_mode | ctl_hold),
        .scl      (pin_q[1]),
        .sda      (pin_q[0]),
        .scl_rise (pin_rise[1]),
        .scl_fall (pin_fall[1]),
        .sda_rise (pin_rise[0]),
        .sda_fall (pin_fall[0]),
        .adr_a    (adr_a),
        .adr_b    (adr_b),
        .tx_byte  (tx_byte),
        .state_o  (eng_state),
        .sda_drive(sda_drive),
        .xmit     (xmit),
        .byte_evt (byte_evt),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    tw_regs #(.ADRA_INIT(ADRA_INIT), .ADRB_INIT(ADRB_INIT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .scl_edge (pin_rise[1] | pin_fall[1]),
        .sda_now  (pin_q[0]),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .byte_evt (byte_evt),
        .xmit     (xmit),
        .ctl_dout (ctl_dout),
        .ctl_doe  (ctl_doe),
        .ctl_clk  (ctl_clk),
        .ctl_mode (ctl_mode),
        .ctl_hold (ctl_hold),
        .tx_byte  (tx_byte),
        .adr_a    (adr_a),
        .adr_b    (adr_b),
        .flag     (irq)
    );

    // open-drain pin selection
    always_comb begin
        if (ctl_mode) begin
            scl_oe = ~ctl_clk;
            sda_oe = ctl_doe & ~ctl_dout;
        end else begin
            scl_oe = 1'b0;
            sda_oe = sda_drive;
        end
    end

endmodule

// File: rtl/tw_serial_unit_chk.sv
module tw_serial_unit_chk
    import tw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic       ctl_mode,
    input logic       ctl_doe,
    input logic       ctl_hold,
    input slv_state_e eng_state,
    input logic       byte_evt,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq
);

    p_slave_scl_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_mode |-> !scl_oe);

    p_master_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && !ctl_doe) |-> !sda_oe);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hold || ctl_mode) |=> (eng_state == S_IDLE));

    p_ack_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_mode && (eng_state == S_AACK || eng_state == S_RACK)) |-> sda_oe);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(byte_evt));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == RA_DATA && !byte_evt) |=> !irq);

endmodule

bind tw_serial_unit tw_serial_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .ctl_mode (ctl_mode),
    .ctl_doe  (ctl_doe),
    .ctl_hold (ctl_hold),
    .eng_state(eng_state),
    .byte_evt (byte_evt),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .irq      (irq)
);

// File: tb/tw_serial_unit_tb.sv
`timescale 1ns/1ps
module tw_serial_unit_tb;

    localparam int PH = 10;
    localparam logic [1:0] A_CTL = 2'd0, A_DAT = 2'd1, A_ADA = 2'd2, A_ADB = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic       scl_line, sda_line;
    int         checks = 0, fails = 0, scl_viol = 0;
    bit         slave_mode_tb = 1'b1;
    logic [6:0] adr_a_v, adr_b_v;

    assign scl_line = ~(scl_oe | tb_scl_low);
    assign sda_line = ~(sda_oe | tb_sda_low);

    always #10 clk = ~clk;

    tw_serial_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .irq(irq)
    );

    always @(negedge clk) if (rst_n && slave_mode_tb && scl_oe) scl_viol++;

    function automatic bit exp_ack(input logic [6:0] a, input logic [6:0] ra, input logic [6:0] rb);
        return (a == ra) || (a == rb);
    endfunction

    function automatic bit exp_sda(input logic [7:0] c);
        return !(c[6] && !c[7]);
    endfunction

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ph;
        repeat (PH) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic m_start;
        tb_sda_low = 1'b0; wait_ph;
        tb_scl_low = 1'b0; wait_ph;
        tb_sda_low = 1'b1; wait_ph;
        tb_scl_low = 1'b1; wait_ph;
    endtask

    task automatic m_stop;
        tb_sda_low = 1'b1; wait_ph;
        tb_scl_low = 1'b0; wait_ph;
        tb_sda_low = 1'b0; wait_ph;
    endtask

    task automatic m_bit_out(input bit b);
        tb_sda_low = !b; wait_ph;
        tb_scl_low = 1'b0; wait_ph;
        tb_scl_low = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic m_bit_in(output bit b);
        tb_sda_low = 1'b0; wait_ph;
        tb_scl_low = 1'b0; wait_ph;
        b = sda_line;
        tb_scl_low = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
        m_bit_in(a);
        ack = !a;
    endtask

    task automatic recv8(output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(b);
            d[i] = b;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rv, c, b, tx;
        logic [6:0] a;
        bit ack, rw;
        int pick, n;
        void'($urandom(32'h5EED_1234));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        bus_read(A_CTL, rv); check("R1 ctrl", rv, 8'h00);
        bus_read(A_ADB, rv); check("R1 adrB", rv, 8'h7F);
        bus_read(A_ADA, rv); check("R1 adrA", rv, 8'h00);
        bus_read(A_DAT, rv); check("R1 data", rv, 8'h00);
        check("R1 scl", scl_line, 1'b1);
        check("R1 sda", sda_line, 1'b1);
        check("R1 irq", irq, 1'b0);

        // R2 / R3 firmware pin control
        slave_mode_tb = 1'b0;
        bus_write(A_CTL, 8'b1100_1000);
        check("R2 dout1", sda_line, 1'b1); check("R3 clk0", scl_line, 1'b0);
        bus_write(A_CTL, 8'b0110_1000);
        check("R2 dout0", sda_line, 1'b0); check("R3 clk1", scl_line, 1'b1);
        bus_write(A_CTL, 8'b0010_1000);
        check("R2 release", sda_line, 1'b1);
        for (int i = 0; i < 6; i++) begin
            c = {3'($urandom), 5'b0_1000};
            bus_write(A_CTL, c);
            repeat (2) @(negedge clk);
            check("R2 rand", sda_line, exp_sda(c));
            check("R3 rand", scl_line, c[5]);
        end

        // R4 capture on clock transitions
        tb_sda_low = 1'b0;
        bus_write(A_CTL, 8'b0000_1000); repeat (6) @(negedge clk);
        bus_write(A_CTL, 8'b0010_1000); repeat (6) @(negedge clk);
        bus_read(A_CTL, rv); check("R4 latch1", rv[4], 1'b1);
        tb_sda_low = 1'b1; repeat (8) @(negedge clk);
        bus_read(A_CTL, rv); check("R4 noedge", rv[4], 1'b1);
        bus_write(A_CTL, 8'b0001_1000); repeat (6) @(negedge clk);
        bus_read(A_CTL, rv); check("R4 latch0 wr-ignored", rv[4], 1'b0);
        tb_sda_low = 1'b0;
        bus_write(A_CTL, 8'b1110_1000); repeat (6) @(negedge clk);
        bus_read(A_CTL, rv); check("R4 doe-blocks", rv[4], 1'b0);
        bus_write(A_CTL, 8'h00); repeat (6) @(negedge clk);
        slave_mode_tb = 1'b1;

        // R11 firmware bits have no effect in slave mode
        bus_write(A_CTL, 8'b0100_0000); repeat (4) @(negedge clk);
        check("R11 sda", sda_line, 1'b1); check("R11 scl", scl_line, 1'b1);
        bus_write(A_CTL, 8'h00);

        // R5 / R6 / R8 write transfer
        adr_a_v = 7'h2C; adr_b_v = 7'h7F;
        bus_write(A_ADA, {1'b0, adr_a_v});
        bus_read(A_ADA, rv); check("R5 adrA wr", rv, {1'b0, adr_a_v});
        bus_write(A_CTL, 8'h01); bus_read(A_CTL, rv);
        check("R8 flag wr ignored", rv, 8'h00); check("R8 irq low", irq, 1'b0);
        m_start;
        send_byte({adr_a_v, 1'b0}, ack);
        check("R5 ackA", ack, 1'b1);
        check("R8 addr flag", irq, 1'b1);
        bus_write(A_CTL, 8'h00); check("R8 flag wr0 ignored", irq, 1'b1);
        bus_read(A_DAT, rv); check("R8 rd clears", irq, 1'b0);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom);
            send_byte(b, ack);
            check("R6 ack", ack, 1'b1);
            check("R8 byte flag", irq, 1'b1);
            bus_read(A_DAT, rv);
            check("R6 data", rv, b);
        end
        m_stop;

        // R5 second register default
        m_start; send_byte({adr_b_v, 1'b0}, ack); check("R5 ackB", ack, 1'b1);
        m_stop; bus_read(A_DAT, rv);

        // R5 mismatch then ignored
        bus_write(A_DAT, 8'h3C);
        m_start; send_byte({7'h11, 1'b0}, ack); check("R5 nack", ack, 1'b0);
        send_byte(8'hA5, ack); check("R5 ignored ack", ack, 1'b0);
        check("R5 ignored irq", irq, 1'b0);
        bus_read(A_DAT, rv); check("R5 ignored data", rv, 8'h3C);
        m_stop;

        // R7 read transfer
        bus_write(A_DAT, 8'hB6);
        m_start; send_byte({adr_a_v, 1'b1}, ack); check("R7 addr ack", ack, 1'b1);
        bus_read(A_CTL, rv); check("R7 dir tx", rv[1], 1'b1);
        bus_read(A_DAT, rv);
        recv8(rv); check("R7 byte0", rv, 8'hB6);
        check("R8 tx flag", irq, 1'b1);
        bus_read(A_DAT, rv);
        bus_write(A_DAT, 8'h4D);
        m_bit_out(1'b0);
        recv8(rv); check("R7 byte1", rv, 8'h4D);
        m_bit_out(1'b1);
        bus_read(A_CTL, rv); check("R7 dir after nack", rv[1], 1'b0);
        m_stop; bus_read(A_DAT, rv);

        // R9 slave hold
        bus_write(A_CTL, 8'h04); bus_read(A_CTL, rv); check("R9 ctrl", rv, 8'h04);
        m_start; send_byte({adr_a_v, 1'b0}, ack);
        check("R9 no ack", ack, 1'b0); check("R9 no irq", irq, 1'b0);
        m_stop; bus_write(A_CTL, 8'h00);

        // R10 repeated START and STOP mid-address
        bus_write(A_DAT, 8'h00);
        m_start; send_byte({adr_a_v, 1'b0}, ack); check("R10 first ack", ack, 1'b1);
        send_byte(8'h9E, ack);
        bus_read(A_DAT, rv); check("R10 wr data", rv, 8'h9E);
        m_start; send_byte({adr_a_v, 1'b1}, ack); check("R10 restart ack", ack, 1'b1);
        recv8(rv); check("R10 restart read", rv, 8'h9E);
        m_bit_out(1'b1); m_stop; bus_read(A_DAT, rv);
        m_start; m_bit_out(1'b0); m_bit_out(1'b1); m_stop;
        tb_scl_low = 1'b1; wait_ph;
        send_byte({adr_a_v, 1'b0}, ack); check("R10 idle after stop", ack, 1'b0);
        m_stop;

        // random transactions
        for (int it = 0; it < 10; it++) begin
            bus_read(A_DAT, rv);
            tx = 8'($urandom); bus_write(A_DAT, tx);
            rw = 1'($urandom); pick = $urandom % 3;
            if (pick == 0) a = adr_a_v;
            else if (pick == 1) a = adr_b_v;
            else begin
                a = 7'($urandom);
                while (exp_ack(a, adr_a_v, adr_b_v)) a = 7'($urandom);
            end
            m_start; send_byte({a, rw}, ack);
            check("R5 rand", ack, exp_ack(a, adr_a_v, adr_b_v));
            if (!ack) begin
                check("R5 rand irq", irq, 1'b0);
            end else if (rw) begin
                bus_read(A_DAT, rv);
                recv8(rv); check("R7 rand", rv, tx);
                m_bit_out(1'b1);
            end else begin
                n = 1 + ($urandom % 2);
                for (int k = 0; k < n; k++) begin
                    b = 8'($urandom);
                    send_byte(b, ack); check("R6 rand ack", ack, 1'b1);
                    bus_read(A_DAT, rv); check("R6 rand data", rv, b);
                end
            end
            m_stop;
        end

        check("R11 scl never driven", scl_viol, 0);
        finish_run();
    end

endmodule